// File: doc/BRIEF.md
# Output-Layer Weight Update Engine

This coprocessor performs the output-layer weight step of a small backpropagation network with 8 hidden units and 4 output units. For every hidden unit i and output unit j it replaces the weight v[i][j] with v[i][j] + alpha * a[i] * e[j]. Here a[i] is the hidden activation, e[j] is the output error term and alpha is the learning rate. All values are signed 16-bit Q8.8 fixed point. The forward pass, the hidden-layer update and anything on the 400-pixel input side are handled elsewhere.

A host streams the operands in over a valid/ready input channel and collects the 32 updated weights from a valid/ready output channel. A word moves on either channel only on a rising clock edge where both valid and ready are high. The engine holds off input by dropping `in_ready` whenever it is not collecting operands. A sink that holds `out_ready` low stalls the output: the offered word stays unchanged until it is taken.

Three phases repeat in a fixed cycle. Collect gathers 45 operand words. Compute updates one weight per clock. Drain returns the weights. Each phase ends when a counter reaches its limit.

Top module: `bpw_engine`

## Requirements
- R1: `phase` reads 00 while collecting, 10 while computing and 01 while draining. It never reads 11. After reset it reads 00, with `in_ready` high and `out_valid` low.
- R2: `in_ready` is high only in the collect phase, and only until 45 words have been accepted. A word is accepted only on an edge where `in_valid` and `in_ready` are both high.
- R3: The accepted words are taken in this order: alpha first, then a[0]..a[7], then e[0]..e[3], then the 32 weights in row-major order (index i*4+j). The phase becomes 10 on the edge after the 45th word is accepted.
- R4: Each updated weight equals sat(v + sat(rnd(sat(rnd(alpha*a[i])) * e[j]))). Here rnd(x) = floor((x+128)/256) applied to the raw Q16.16 product. sat clamps the result to the range -32768..32767.
- R5: The compute phase lasts exactly 33 cycles: one weight per cycle for 32 cycles, then one cycle for the completion flag. The phase then becomes 01.
- R6: In the drain phase, `out_valid` presents the 32 updated weights in row-major order. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change. `out_valid` is never high outside the drain phase.
- R7: On the edge after the 32nd output word is taken, the phase returns to 00 and `in_ready` rises again.
- R8: `in_valid` and `in_data` have no effect outside the collect phase. Words offered during compute or drain are not taken, and they do not change any result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Engine will take the input word |
| in_data | input | 16 | Operand word, Q8.8 |
| out_valid | output | 1 | Updated weight offered |
| out_ready | input | 1 | Sink will take the output word |
| out_data | output | 16 | Updated weight, Q8.8 |
| phase | output | 2 | Controller phase code |

## Verification
Signals change on these edges, counted from the edge that accepts the 45th operand word:
- The phase code changes to 10 on the next edge.
- The drain phase and `out_valid` appear 33 edges after that.
- Each output word leaves on the edge where `out_ready` is high.
- The phase returns to 00 one edge after the last transfer.

The bench keeps its own model of phases and counters, stepped on each rising edge from the same inputs. It compares every output at the following falling edge, so each result is checked in the cycle it is due. Hand-computed weight lists for saturation, rounding and ordering cases are checked against the words as they are transferred.

// File: rtl/bpw_pkg.sv
package bpw_pkg;
  typedef enum logic [1:0] {
    PH_COLLECT = 2'b00,
    PH_COMPUTE = 2'b10,
    PH_DRAIN   = 2'b01
  } bpw_phase_e;
endpackage

// File: rtl/bpw_cnt.sv
module bpw_cnt #(
  parameter int LIMIT = 32,
  parameter int CW    = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          full
);
  assign full = (cnt == CW'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (clr)           cnt <= '0;
    else if (inc && !full)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bpw_mac.sv
module bpw_mac #(
  parameter int DW   = 16,
  parameter int FRAC = 8
) (
  input  logic signed [DW-1:0] rate,
  input  logic signed [DW-1:0] act,
  input  logic signed [DW-1:0] err,
  input  logic signed [DW-1:0] wt,
  output logic signed [DW-1:0] wt_new
);
  localparam int PW = 2 * DW;
  localparam logic signed [PW:0] MAXV = (PW+1)'((64'sd1 <<< (DW - 1)) - 1);
  localparam logic signed [PW:0] MINV = -MAXV - 1;
  localparam logic signed [PW:0] RND  = (PW+1)'(64'sd1 <<< (FRAC - 1));

  function automatic logic signed [DW-1:0] clamp(input logic signed [PW:0] x);
    if (x > MAXV)      return MAXV[DW-1:0];
    else if (x < MINV) return MINV[DW-1:0];
    else               return x[DW-1:0];
  endfunction

  logic signed [PW-1:0] m1, m2;
  logic signed [PW:0]   m1x, m2x, r1, r2, sum;
  logic signed [DW-1:0] p1, p2;

  assign m1  = rate * act;
  assign m1x = m1;
  assign r1  = (m1x + RND) >>> FRAC;
  assign p1  = clamp(r1);

  assign m2  = p1 * err;
  assign m2x = m2;
  assign r2  = (m2x + RND) >>> FRAC;
  assign p2  = clamp(r2);

  assign sum    = (PW+1)'(wt) + (PW+1)'(p2);
  assign wt_new = clamp(sum);
endmodule

// File: rtl/bpw_engine.sv
module bpw_engine #(
  parameter int HID  = 8,
  parameter int OUTN = 4,
  parameter int DW   = 16,
  parameter int FRAC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic [1:0]    phase
);
  import bpw_pkg::*;

  localparam int NW    = HID * OUTN;
  localparam int NLOAD = 1 + HID + OUTN + NW;
  localparam int LW    = $clog2(NLOAD + 1);
  localparam int UW    = $clog2(NW + 1);
  localparam int HW    = $clog2(HID);
  localparam int OW    = $clog2(OUTN);
  localparam int WW    = $clog2(NW);

  bpw_phase_e st;

  logic [LW-1:0] ld_cnt;
  logic [UW-1:0] up_cnt, sd_cnt;
  logic          ld_full, up_full, sd_full;
  logic          ld_acc, up_inc, sd_inc;

  logic signed [DW-1:0] rate_q;
  logic signed [DW-1:0] act_q [HID];
  logic signed [DW-1:0] err_q [OUTN];
  logic signed [DW-1:0] wt_q  [NW];
  logic signed [DW-1:0] wt_new;

  logic [WW-1:0] up_idx;

  assign in_ready  = (st == PH_COLLECT) && !ld_full;
  assign out_valid = (st == PH_DRAIN) && !sd_full;
  assign ld_acc    = in_valid && in_ready;
  assign up_inc    = (st == PH_COMPUTE) && !up_full;
  assign sd_inc    = out_valid && out_ready;
  assign up_idx    = up_cnt[WW-1:0];
  assign out_data  = wt_q[sd_cnt[WW-1:0]];
  assign phase     = st;

  bpw_cnt #(.LIMIT(NLOAD), .CW(LW)) u_load_cnt (
    .clk(clk), .rst_n(rst_n), .clr((st == PH_COLLECT) && ld_full),
    .inc(ld_acc), .cnt(ld_cnt), .full(ld_full));

  bpw_cnt #(.LIMIT(NW), .CW(UW)) u_upd_cnt (
    .clk(clk), .rst_n(rst_n), .clr((st == PH_COMPUTE) && up_full),
    .inc(up_inc), .cnt(up_cnt), .full(up_full));

  bpw_cnt #(.LIMIT(NW), .CW(UW)) u_send_cnt (
    .clk(clk), .rst_n(rst_n), .clr((st == PH_DRAIN) && sd_full),
    .inc(sd_inc), .cnt(sd_cnt), .full(sd_full));

  bpw_mac #(.DW(DW), .FRAC(FRAC)) u_mac (
    .rate(rate_q),
    .act(act_q[up_idx[WW-1:OW]]),
    .err(err_q[up_idx[OW-1:0]]),
    .wt(wt_q[up_idx]),
    .wt_new(wt_new));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= PH_COLLECT;
    else begin
      unique case (st)
        PH_COLLECT: if (ld_full) st <= PH_COMPUTE;
        PH_COMPUTE: if (up_full) st <= PH_DRAIN;
        PH_DRAIN:   if (sd_full) st <= PH_COLLECT;
        default:    st <= PH_COLLECT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      for (int h = 0; h < HID; h++)  act_q[h] <= '0;
      for (int o = 0; o < OUTN; o++) err_q[o] <= '0;
      for (int k = 0; k < NW; k++)   wt_q[k]  <= '0;
    end else begin
      if (ld_acc) begin
        if (ld_cnt == '0)
          rate_q <= in_data;
        else if (ld_cnt <= LW'(HID))
          act_q[HW'(ld_cnt - LW'(1))] <= in_data;
        else if (ld_cnt <= LW'(HID + OUTN))
          err_q[OW'(ld_cnt - LW'(1 + HID))] <= in_data;
        else
          wt_q[WW'(ld_cnt - LW'(1 + HID + OUTN))] <= in_data;
      end
      if (up_inc) wt_q[up_idx] <= wt_new;
    end
  end
endmodule

// File: rtl/bpw_engine_chk.sv
module bpw_engine_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic [1:0]    phase
);
  assert_legal_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'b11);

  assert_ready_in_collect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> phase == 2'b00);

  assert_collect_to_compute_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b00 && !in_ready) |=> phase == 2'b10);

  assert_compute_no_collect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 2'b10 |=> phase != 2'b00);

  assert_valid_in_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> phase == 2'b01);

  assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_drain_to_collect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b01 && !out_valid) |=> (phase == 2'b00 && in_ready));

  assert_no_take_outside_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && phase != 2'b00) |-> !in_ready);
endmodule

bind bpw_engine bpw_engine_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .phase(phase));

// File: tb/sim_bpw_engine.sv
`timescale 1ns/1ps
module sim_bpw_engine;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1;
  logic [15:0] out_data;
  logic [1:0]  phase;

  always #4 clk = ~clk;

  bpw_engine u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .phase(phase));

  int checks = 0, errors = 0, cyc = 0, rcv = 0;
  bit done = 0, bp_on = 0, hand_on = 0;

  int t_rate, t_a[8], t_e[4], t_w[32], exp_w[32];

  // behavioural reference: 0 collect, 1 compute, 2 drain
  int m_st = 0, m_ld = 0, m_idx = 0, m_snd = 0;
  int m_rate, m_a[8], m_e[4], m_w[32];

  function automatic int clampi(int x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction
  function automatic int rndq(int p);
    return (p + 128) >>> 8;
  endfunction
  function automatic int upd(int w, int r, int a, int e);
    int p1;
    p1 = clampi(rndq(r * a));
    return clampi(w + clampi(rndq(p1 * e)));
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_ld = 0; m_idx = 0; m_snd = 0;
    end else begin
      case (m_st)
        0: if (m_ld == 45) begin m_st = 1; m_ld = 0; m_idx = 0; end
           else if (in_valid) begin
             if (m_ld == 0) m_rate = int'($signed(in_data));
             else if (m_ld <= 8) m_a[m_ld-1] = int'($signed(in_data));
             else if (m_ld <= 12) m_e[m_ld-9] = int'($signed(in_data));
             else m_w[m_ld-13] = int'($signed(in_data));
             m_ld++;
           end
        1: if (m_idx < 32) begin
             m_w[m_idx] = upd(m_w[m_idx], m_rate, m_a[m_idx/4], m_e[m_idx%4]);
             m_idx++;
           end else begin m_st = 2; m_snd = 0; end
        default: if (m_snd == 32) m_st = 0;
                 else if (out_ready) m_snd++;
      endcase
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit mv, mr;
      logic [1:0] mcode;
      out_ready = bp_on ? (cyc % 3 != 0) : 1'b1;
      mcode = (m_st == 0) ? 2'b00 : (m_st == 1) ? 2'b10 : 2'b01;
      mr = (m_st == 0) && (m_ld < 45);
      mv = (m_st == 2) && (m_snd < 32);
      chk(phase == mcode, m_st == 0 ? "R3 phase" : m_st == 1 ? "R5 phase" : "R7 phase",
          phase, mcode);
      chk(in_ready == mr, (in_valid && m_st != 0) ? "R8 in_ready" : "R2 in_ready",
          in_ready, mr);
      chk(out_valid == mv, "R6 out_valid", out_valid, mv);
      if (mv) chk(out_data == 16'(m_w[m_snd]), "R4 out_data", out_data, 16'(m_w[m_snd]));
      if (out_valid && out_ready) begin
        if (hand_on && rcv < 32)
          chk(out_data == 16'(exp_w[rcv]), "R6 order/R4 value", out_data, 16'(exp_w[rcv]));
        rcv++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
    end
  end

  task automatic push(int d);
    bit acc;
    in_valid = 1; in_data = 16'(d);
    do begin acc = in_ready; @(negedge clk); end while (!acc);
    in_valid = 0;
  endtask

  task automatic run_pass(bit gaps);
    push(t_rate);
    for (int i = 0; i < 8; i++) push(t_a[i]);
    for (int j = 0; j < 4; j++) begin push(t_e[j]); if (gaps) @(negedge clk); end
    for (int k = 0; k < 32; k++) begin push(t_w[k]); if (gaps && k % 5 == 0) @(negedge clk); end
    // R8: offer junk while the engine is busy
    in_valid = 1; in_data = 16'hDEAD;
    repeat (20) @(negedge clk);
    in_valid = 0;
    while (rcv < 32) @(negedge clk);
    @(negedge clk);
    chk(phase == 2'b00 && in_ready, "R7 back to collect", {phase, in_ready}, 3'b001);
    rcv = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(phase == 2'b00, "R1 reset phase", phase, 0);
    chk(in_ready == 1, "R1 reset in_ready", in_ready, 1);
    chk(out_valid == 0, "R1 reset out_valid", out_valid, 0);

    // pass 1: plain values, w = 0, result = a[i]
    t_rate = 16'h0100;
    for (int i = 0; i < 8; i++) t_a[i] = i * 32;
    for (int j = 0; j < 4; j++) t_e[j] = 16'h0100;
    for (int k = 0; k < 32; k++) begin t_w[k] = 0; exp_w[k] = (k / 4) * 32; end
    hand_on = 1; bp_on = 0;
    run_pass(0);

    // pass 2: saturation, stalled sink (R4 R6)
    t_rate = 16'h7FFF;
    for (int i = 0; i < 8; i++) t_a[i] = 16'h7FFF;
    t_e[0] = 16'h7FFF; t_e[1] = 16'h8000; t_e[2] = 0; t_e[3] = 1;
    for (int k = 0; k < 32; k++) begin
      t_w[k] = 16'h7000;
      case (k % 4)
        0: exp_w[k] = 16'h7FFF;
        1: exp_w[k] = 16'hF000;
        2: exp_w[k] = 16'h7000;
        default: exp_w[k] = 16'h7080;
      endcase
    end
    bp_on = 1;
    run_pass(1);

    // pass 3: rounding at the half step (R4)
    t_rate = 16'h0080;
    for (int i = 0; i < 8; i++) t_a[i] = 1;
    t_e[0] = 16'h0100; t_e[1] = 16'h0080; t_e[2] = 16'h007F; t_e[3] = 16'hFF80;
    for (int k = 0; k < 32; k++) begin
      t_w[k] = 0;
      exp_w[k] = (k % 4 < 2) ? 1 : 0;
    end
    bp_on = 0;
    run_pass(0);

    // pass 4: mixed signs, model only, stalled sink
    hand_on = 0; bp_on = 1;
    t_rate = 16'h0040;
    for (int i = 0; i < 8; i++) t_a[i] = (i * 16'h0123) ^ 16'h8421;
    for (int j = 0; j < 4; j++) t_e[j] = (j * 16'h3001) + 16'hF100;
    for (int k = 0; k < 32; k++) t_w[k] = (k * 16'h0777) & 16'hFFFF;
    run_pass(1);

    done = 1;
    summary();
  end
endmodule